// File: doc/BRIEF.md
# Dual-Lane 16-bit Vector Shifter

This block shifts a 32-bit word as two independent 16-bit lanes. Both lanes use one shared signed shift amount. A positive amount shifts left and a negative amount shifts right. The block has two modes:

- **Arithmetic mode** fills right shifts with the sign bit. It can also clamp left shifts that overflow a lane to the most positive or most negative 16-bit value.
- **Logical mode** fills right shifts with zeros.

Each operation presented with `in_valid` is captured in one register stage. One clock later the block presents:

- the 32-bit result;
- a zero flag and a negative flag, each combining both lanes;
- a carry flag and two overflow flags, which a vector shift always clears.

A datapath instantiates the block where a packed pair of 16-bit values needs the same shift. The block accepts one operation per cycle.

Top module: `dual_lane_shifter`

## Requirements
- R1: The upper lane (bits 31:16) and the lower lane (bits 15:0) are shifted independently, by the same amount, with no bit crossing between lanes.
- R2: Only `shamt[4:0]` is used, read as a two's-complement count from -16 to +15. Non-negative values shift left and negative values shift right by their magnitude. `shamt[15:5]` has no effect.
- R3: A left shift with saturation off drops the bits that leave the lane and fills with zeros. A left shift in logical mode gives the same result.
- R4: An arithmetic left shift with `sat_en`=1 clamps a lane to 0x7FFF when that lane was non-negative, or to 0x8000 when it was negative, if the shifted value does not fit in 16 signed bits.
- R5: An arithmetic left shift with `sat_en`=1 whose value still fits gives the same result as with `sat_en`=0. A shift of zero returns the lane unchanged.
- R6: An arithmetic right shift fills with copies of the lane's sign bit. A count of -16 gives 0xFFFF for a negative lane and 0x0000 otherwise.
- R7: A logical right shift (`logical`=1) fills with zeros, and a count of -16 gives 0x0000. `sat_en` has no effect in logical mode.
- R8: `sat_en` has no effect on arithmetic right shifts.
- R9: `flag_zero` is 1 when either lane of the result is 0x0000. `flag_neg` is 1 when bit 15 or bit 31 of the result is set.
- R10: `flag_carry`, `flag_ovf0` and `flag_ovf1` are 0 after every operation, including one that saturates.
- R11: The result and flags appear one clock after an operation is presented with `in_valid`=1. `out_valid` is `in_valid` delayed by one clock. While `in_valid`=0, `result` and the flags hold their last values.
- R12: A synchronous active-high `rst` clears `out_valid`, `result` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 32 | Two packed 16-bit lanes |
| shamt | input | 16 | Shift control; bits 4:0 are a signed count |
| logical | input | 1 | 1 selects logical mode, 0 selects arithmetic mode |
| sat_en | input | 1 | Saturate arithmetic left shifts |
| out_valid | output | 1 | Result and flags updated this cycle |
| result | output | 32 | Shifted lanes |
| flag_zero | output | 1 | Either lane of the result is zero |
| flag_neg | output | 1 | Either lane of the result is negative |
| flag_carry | output | 1 | Carry flag, always cleared |
| flag_ovf0 | output | 1 | Overflow flag 0, always cleared |
| flag_ovf1 | output | 1 | Overflow flag 1, always cleared |

## Verification
The bench covers the following corner cases and the failure each one exposes:

- **Counts of +15 and -16.** A design that treats -16 as zero, or as +16, returns the lane unchanged or zero instead of the sign fill.
- **Saturating left shifts.** These cover a negative lane that loses its sign, a positive lane that overflows, and a lane that still fits. A design with a wrong fit test either clamps lanes that fit or lets through wrapped values.
- **Right shifts and logical mode with saturation on.** A design that applies the clamp outside the arithmetic left case corrupts these results.
- **Zero/negative flags.** These are checked on cases where only one lane is zero or negative, which catches flags built from the whole word.
- **Shift counts with high bits set.** A design that decodes more than five bits shifts by the wrong count.

// File: rtl/dual_lane_shifter.sv
`timescale 1ns/1ps
module dual_lane_shifter #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int CTRL_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] operand,
  input  logic [CTRL_W-1:0]       shamt,
  input  logic                    logical,
  input  logic                    sat_en,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result,
  output logic                    flag_zero,
  output logic                    flag_neg,
  output logic                    flag_carry,
  output logic                    flag_ovf0,
  output logic                    flag_ovf1
);
  localparam int SW = $clog2(LANE_W) + 1;
  localparam int DW = LANES * LANE_W;

  function automatic logic [LANE_W-1:0] lane_shift(
    input logic [LANE_W-1:0] x,
    input logic [SW-1:0]     s,
    input logic              lg,
    input logic              sat
  );
    logic [SW-1:0]            mag;
    logic [LANE_W-1:0]        left;
    logic signed [LANE_W-1:0] back;
    logic [2*LANE_W-1:0]      ext;
    logic [2*LANE_W-1:0]      shr;
    if (!s[SW-1]) begin
      left = x << s;
      back = $signed(left) >>> s;
      if (!lg && sat && (back != $signed(x)))
        lane_shift = x[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                 : {1'b0, {(LANE_W-1){1'b1}}};
      else
        lane_shift = left;
    end else begin
      mag = -s;
      ext = lg ? {{LANE_W{1'b0}}, x} : {{LANE_W{x[LANE_W-1]}}, x};
      shr = ext >> mag;
      lane_shift = shr[LANE_W-1:0];
    end
  endfunction

  logic [DW-1:0]    nxt;
  logic [LANES-1:0] lane_zero, lane_neg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nxt[g*LANE_W +: LANE_W] =
      lane_shift(operand[g*LANE_W +: LANE_W], shamt[SW-1:0], logical, sat_en);
    assign lane_zero[g] = (nxt[g*LANE_W +: LANE_W] == '0);
    assign lane_neg[g]  = nxt[g*LANE_W + LANE_W - 1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      flag_zero  <= 1'b0;
      flag_neg   <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf0  <= 1'b0;
      flag_ovf1  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= nxt;
        flag_zero  <= |lane_zero;
        flag_neg   <= |lane_neg;
        flag_carry <= 1'b0;
        flag_ovf0  <= 1'b0;
        flag_ovf1  <= 1'b0;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid && result == '0 && !flag_zero && !flag_neg); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result) && $stable(flag_zero) && $stable(flag_neg)); // R11
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R11
  AST_SAT_KEEPS_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && !logical && sat_en && !shamt[SW-1] |=>
      result[LANE_W-1] == $past(operand[LANE_W-1]) && result[DW-1] == $past(operand[DW-1])); // R4
  AST_ARITH_RIGHT_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && !logical && shamt[SW-1] |=>
      result[LANE_W-1] == $past(operand[LANE_W-1]) && result[DW-1] == $past(operand[DW-1])); // R6
  AST_LOGIC_RIGHT_TOP: assert property (@(posedge clk) disable iff (rst)
    in_valid && logical && shamt[SW-1] |=> !result[LANE_W-1] && !result[DW-1]); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flag_zero == (result[LANE_W-1:0] == '0 || result[DW-1:LANE_W] == '0)); // R9
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flag_neg == (result[LANE_W-1] || result[DW-1])); // R9
endmodule

// File: tb/sim_dual_lane_shifter.sv
`timescale 1ns/1ps
module sim_dual_lane_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [15:0] shamt = '0;
  logic        logical = 1'b0;
  logic        sat_en = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dual_lane_shifter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand), .shamt(shamt),
    .logical(logical), .sat_en(sat_en), .out_valid(out_valid), .result(result),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_carry(flag_carry),
    .flag_ovf0(flag_ovf0), .flag_ovf1(flag_ovf1)
  );

  // {operand, shamt, logical, sat_en, expected result, flags {zero,neg,carry,ovf0,ovf1}}
  localparam int NV = 15;
  localparam logic [86:0] VEC [NV] = '{
    {32'h0100_8001, 16'h000F, 1'b0, 1'b0, 32'h0000_8000, 5'b11000}, // R3 R9
    {32'h0100_8001, 16'h000F, 1'b0, 1'b1, 32'h7FFF_8000, 5'b01000}, // R4 R10
    {32'h0100_8001, 16'h0001, 1'b0, 1'b0, 32'h0200_0002, 5'b00000}, // R3 R1
    {32'h0100_8001, 16'h0001, 1'b0, 1'b1, 32'h0200_8000, 5'b01000}, // R4 R5
    {32'h0000_FFF0, 16'h000F, 1'b0, 1'b1, 32'h0000_8000, 5'b11000}, // R4
    {32'h0100_8000, 16'hFFF1, 1'b0, 1'b0, 32'h0000_FFFF, 5'b11000}, // R6
    {32'h0100_8000, 16'hFFF1, 1'b0, 1'b1, 32'h0000_FFFF, 5'b11000}, // R8
    {32'h0100_8000, 16'hFFF1, 1'b1, 1'b0, 32'h0000_0001, 5'b10000}, // R7
    {32'h8000_7FFF, 16'hFFF0, 1'b0, 1'b0, 32'hFFFF_0000, 5'b11000}, // R6 -16
    {32'h8000_7FFF, 16'hFFF0, 1'b1, 1'b1, 32'h0000_0000, 5'b10000}, // R7 -16
    {32'h0001_0002, 16'h0021, 1'b0, 1'b0, 32'h0002_0004, 5'b00000}, // R2 high bits
    {32'h0100_8001, 16'h0001, 1'b1, 1'b1, 32'h0200_0002, 5'b00000}, // R7 R3 logical left
    {32'h1234_8765, 16'h0000, 1'b0, 1'b1, 32'h1234_8765, 5'b01000}, // R5 zero count
    {32'h7FF0_F00F, 16'hFFFC, 1'b0, 1'b0, 32'h07FF_FF00, 5'b01000}, // R6 R1
    {32'h0001_FFF0, 16'h0004, 1'b0, 1'b1, 32'h0010_FF00, 5'b01000}  // R5 fits
  };

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] op, input logic [15:0] sa, input logic lg, input logic st);
    @(negedge clk);
    operand = op; shamt = sa; logical = lg; sat_en = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [36:0] outs();
    return {result, flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", {out_valid, outs()}, '0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][86:55], VEC[i][54:39], VEC[i][38], VEC[i][37]);
      check($sformatf("R1-vector %0d", i), outs(), VEC[i][36:0]);
      check("R11 out_valid", {36'd0, out_valid}, 37'd1);
    end
    @(negedge clk);
    check("R11 valid drops", {36'd0, out_valid}, 37'd0);
    operand = 32'hDEAD_BEEF; shamt = 16'h0003;
    @(negedge clk);
    check("R11 hold idle", outs(), {32'h0010_FF00, 5'b01000});
    issue(32'h0000_0001, 16'h0001, 1'b0, 1'b0);
    check("R10 R11 back to back a", outs(), {32'h0000_0002, 5'b10000});
    issue(32'h8000_0000, 16'h0001, 1'b0, 1'b1);
    check("R4 R10 both sat", outs(), {32'h8000_0000, 5'b11000});
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset after use", {out_valid, outs()}, '0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule